// File: doc/BRIEF.md
# Sector Product-Code Parity Generator

This block fills in the two parity layers of a 2352-byte optical-disc style sector protected by a product code over GF(2^8). It runs as a bus master on an external sector memory. It reads the sector through a synchronous read port with one cycle of latency, and writes the parity bytes back through a separate write port. Offsets below are relative to sector byte 12. Bytes at even and odd offsets form two independent planes, the low and high halves of 16-bit words.

A job begins with a one-cycle `start` pulse. First, the column layer is computed: 86 vectors of 24 bytes give 172 bytes stored from sector byte 2076. Then the diagonal layer is computed: 52 vectors of 43 bytes give 104 bytes stored from sector byte 2248. The diagonals cover the column parity written earlier in the same job. For each vector, the block keeps a Horner accumulator and a plain XOR sum. From these it forms the two parity symbols, using one division by (alpha+1).

The `zero_addr` input is sampled together with `start`. When it is set, the four header bytes at offsets 0..3 are used as zero during the job, and memory is left untouched. A one-cycle `done` pulse ends the job.

Top module: `rspc_pgen`

## Requirements
- R1: While reset is held, and after it is released until a `start` pulse arrives, `done`, `rd_en` and `wr_en` stay low.
- R2: The field uses polynomial x^8+x^4+x^3+x^2+1 with alpha = x. Column vector k (k = 0..85) reads 24 bytes. The first is at offset 2*(k>>1) + (k&1), and each next one is 86 further on. For data d_0..d_23, let S0 = XOR of all d_i and S1 = XOR of d_i*alpha^(25-i). Then p0 = (S0^S1)/(alpha+1) is written to sector byte 12+2064+k, and p1 = p0^S0 to sector byte 12+2150+k.
- R3: Diagonal vector k (k = 0..51) reads 43 bytes. The first is at offset 86*(k>>1) + (k&1), and each next one is 88 further on, taken modulo 2236. The same formulas, with weights alpha^(44-i), give p0 at sector byte 12+2236+k and p1 at sector byte 12+2288+k.
- R4: Every column parity byte is written before any diagonal read. The diagonal parity is therefore computed from the column parity produced by the same job.
- R5: `zero_addr` is sampled only in the `start` cycle. When it is 1, offsets 0..3 count as zero in both layers, and the memory bytes there are not modified. Later changes of the input have no effect on the running job.
- R6: After a job, every column vector (24 data bytes, then p0 and p1) and every diagonal vector (43 data bytes, then p0 and p1) satisfies both check equations. The XOR of all bytes is zero, and the alpha-weighted sum with weights alpha^(n-1-j) is zero.
- R7: `done` is a one-cycle pulse. By the cycle in which it is high, exactly 276 writes have been committed, each parity address exactly once.
- R8: A `start` pulse that arrives while a job is running is ignored.
- R9: Read data is taken one cycle after `rd_en`. A read and a write never happen in the same cycle.
- R10: Reads stay within sector bytes 12..2247, and writes stay within sector bytes 2076..2351.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that starts a job when idle |
| zero_addr | input | 1 | Treat header offsets 0..3 as zero; sampled with start |
| done | output | 1 | One-cycle pulse when all parity is committed |
| rd_en | output | 1 | Sector memory read enable |
| rd_addr | output | 12 | Sector memory read byte address |
| rd_data | input | 8 | Read data, valid the cycle after rd_en |
| wr_en | output | 1 | Sector memory write enable |
| wr_addr | output | 12 | Sector memory write byte address |
| wr_data | output | 8 | Parity byte to write |

## Verification
The assertions rely on four assumptions about the environment:
- The memory returns read data exactly one cycle after `rd_en`.
- No other agent writes the sector during a job.
- `start` is only ever a short pulse.
- Reset is applied at time zero.

The bench keeps to these assumptions. Its memory model registers the read data on the clock after each read, and the sector contents are changed only between jobs. It also pulses `start` and toggles `zero_addr` in the middle of a run, which exercises the ignore paths while keeping the memory contract intact.

// File: rtl/rspc_pkg.sv
package rspc_pkg;

  // Low byte of the field polynomial x^8+x^4+x^3+x^2+1
  localparam logic [7:0] GF_POLY_LO = 8'h1D;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_WR0,
    ST_WR1,
    ST_DONE
  } pg_state_e;

  function automatic logic [7:0] gf_mulx(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? GF_POLY_LO : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_mulx(sh);
    end
    return acc;
  endfunction

  // Multiplicative inverse by exhaustive search; elaboration-time only
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 1; i < 256; i++) begin
      if (gf_mul(a, 8'(i)) == 8'h01) r = 8'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/rspc_agen.sv
module rspc_agen
#(
  parameter int NCOL = 43,
  parameter int NROW = 24,
  parameter int OW   = 12,
  parameter int VW   = 7
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic          adv,
  input  logic          nxt,
  output logic          pass_q,
  output logic [VW-1:0] vec,
  output logic [OW-1:0] off,
  output logic          elem_last,
  output logic          vec_last
);

  localparam int P_NVEC = 2 * NCOL;
  localparam int Q_NVEC = 2 * (NROW + 2);
  localparam int P_MULT = 2;
  localparam int Q_MULT = 2 * NCOL;
  localparam int P_STEP = 2 * NCOL;
  localparam int Q_STEP = 2 * NCOL + 2;
  localparam int Q_SPAN = 2 * NCOL * (NROW + 2);
  localparam int MAXLEN = (NCOL > NROW) ? NCOL : NROW;
  localparam int EW     = $clog2(MAXLEN);
  localparam int SW     = OW + 1;

  logic [EW-1:0] elem;
  logic [EW-1:0] len_m1;
  logic [VW-1:0] nvec_m1;
  logic [SW-1:0] sum;
  logic [OW-1:0] off_step;

  function automatic logic [OW-1:0] first_off(input logic q, input logic [VW-1:0] k);
    int m;
    m = q ? Q_MULT : P_MULT;
    return OW'(int'(k[VW-1:1]) * m + int'(k[0]));
  endfunction

  assign len_m1    = EW'(pass_q ? NCOL - 1 : NROW - 1);
  assign nvec_m1   = VW'(pass_q ? Q_NVEC - 1 : P_NVEC - 1);
  assign elem_last = (elem == len_m1);
  assign vec_last  = (vec == nvec_m1);

  // Next element offset, wrapping inside the diagonal span
  always_comb begin
    sum = {1'b0, off} + SW'(pass_q ? Q_STEP : P_STEP);
    if (pass_q && (sum >= SW'(Q_SPAN))) sum = sum - SW'(Q_SPAN);
    off_step = sum[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || init) begin
      pass_q <= 1'b0;
      vec    <= '0;
      elem   <= '0;
      off    <= '0;
    end else if (adv) begin
      elem <= elem + 1'b1;
      off  <= off_step;
    end else if (nxt) begin
      elem <= '0;
      if (vec_last) begin
        pass_q <= 1'b1;
        vec    <= '0;
        off    <= first_off(1'b1, '0);
      end else begin
        vec <= vec + 1'b1;
        off <= first_off(pass_q, vec + 1'b1);
      end
    end
  end

  // R3
  off_span_chk: assert property (@(posedge clk) disable iff (rst)
    off < OW'(Q_SPAN));

  // R2
  elem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    elem <= len_m1);

endmodule

// File: rtl/rspc_acc.sv
module rspc_acc
  import rspc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] par0,
  output logic [7:0] par1
);

  // 1/(alpha+1), folded to a constant multiplier
  localparam logic [7:0] INV_A1 = gf_inv(8'h03);

  logic [7:0] acc_h;
  logic [7:0] acc_s;
  logic [7:0] num;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_h <= 8'h00;
      acc_s <= 8'h00;
    end else if (en) begin
      acc_h <= gf_mulx(acc_h ^ din);
      acc_s <= acc_s ^ din;
    end
  end

  assign num  = gf_mulx(acc_h) ^ acc_s;
  assign par0 = gf_mul(num, INV_A1);
  assign par1 = par0 ^ acc_s;

  // R6
  clr_en_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(clr && en));

endmodule

// File: rtl/rspc_pgen.sv
module rspc_pgen
  import rspc_pkg::*;
#(
  parameter int BASE       = 12,
  parameter int NCOL       = 43,
  parameter int NROW       = 24,
  parameter int ZERO_BYTES = 4,
  parameter int AW         = 12
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          zero_addr,
  output logic          done,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);

  localparam int P_NVEC = 2 * NCOL;
  localparam int Q_NVEC = 2 * (NROW + 2);
  localparam int P_PAR  = 2 * NCOL * NROW;
  localparam int Q_SPAN = 2 * NCOL * (NROW + 2);
  localparam int OW     = $clog2(Q_SPAN);
  localparam int VW     = $clog2((P_NVEC > Q_NVEC) ? P_NVEC : Q_NVEC);

  pg_state_e state, state_d;

  logic          zflag;
  logic          ag_init, ag_adv, ag_nxt, acc_clr, iss, wval, wsel;
  logic          pass_q, elem_last, vec_last;
  logic [VW-1:0] vec;
  logic [OW-1:0] off;
  logic          z1, l1, v2, z2, l2, fin;
  logic [7:0]    par0, par1, din;

  rspc_agen #(
    .NCOL(NCOL), .NROW(NROW), .OW(OW), .VW(VW)
  ) u_agen (
    .clk      (clk),
    .rst      (rst),
    .init     (ag_init),
    .adv      (ag_adv),
    .nxt      (ag_nxt),
    .pass_q   (pass_q),
    .vec      (vec),
    .off      (off),
    .elem_last(elem_last),
    .vec_last (vec_last)
  );

  assign din = z2 ? 8'h00 : rd_data;

  rspc_acc u_acc (
    .clk (clk),
    .rst (rst),
    .clr (acc_clr),
    .en  (v2),
    .din (din),
    .par0(par0),
    .par1(par1)
  );

  always_comb begin
    state_d = state;
    ag_init = 1'b0;
    ag_adv  = 1'b0;
    ag_nxt  = 1'b0;
    acc_clr = 1'b0;
    iss     = 1'b0;
    wval    = 1'b0;
    wsel    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          ag_init = 1'b1;
          acc_clr = 1'b1;
          state_d = ST_READ;
        end
      end
      ST_READ: begin
        iss = 1'b1;
        if (elem_last) state_d = ST_WAIT;
        else           ag_adv  = 1'b1;
      end
      ST_WAIT: begin
        if (fin) state_d = ST_WR0;
      end
      ST_WR0: begin
        wval    = 1'b1;
        state_d = ST_WR1;
      end
      ST_WR1: begin
        wval    = 1'b1;
        wsel    = 1'b1;
        acc_clr = 1'b1;
        if (vec_last && pass_q) begin
          state_d = ST_DONE;
        end else begin
          ag_nxt  = 1'b1;
          state_d = ST_READ;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      zflag   <= 1'b0;
      rd_en   <= 1'b0;
      rd_addr <= '0;
      z1      <= 1'b0;
      l1      <= 1'b0;
      v2      <= 1'b0;
      z2      <= 1'b0;
      l2      <= 1'b0;
      fin     <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= 8'h00;
      done    <= 1'b0;
    end else begin
      state <= state_d;
      if (state == ST_IDLE && start) zflag <= zero_addr;
      // read issue stage
      rd_en   <= iss;
      rd_addr <= AW'(BASE) + AW'(off);
      z1      <= iss && zflag && (off < OW'(ZERO_BYTES));
      l1      <= iss && elem_last;
      // data return stage
      v2      <= rd_en;
      z2      <= z1;
      l2      <= l1;
      fin     <= v2 && l2;
      // parity write
      wr_en   <= wval;
      wr_addr <= AW'(pass_q ? BASE + Q_SPAN : BASE + P_PAR) + AW'(vec)
               + (wsel ? AW'(pass_q ? Q_NVEC : P_NVEC) : AW'(0));
      wr_data <= wsel ? par1 : par0;
      done    <= (state == ST_DONE);
    end
  end

  // R10
  rd_range_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (rd_addr >= AW'(BASE)) && (rd_addr < AW'(BASE + Q_SPAN)));

  // R10
  wr_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr >= AW'(BASE + P_PAR)) && (wr_addr < AW'(BASE + Q_SPAN + 2 * Q_NVEC)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  port_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en));

  // R7
  wr_pair_open_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_en) |=> wr_en);

  // R7
  wr_pair_close_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |=> !wr_en);

  // R4
  q_after_p_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr >= AW'(BASE + P_PAR)) |-> pass_q);

endmodule

// File: tb/rspc_pgen_bench.sv
`timescale 1ns/1ps
module rspc_pgen_bench;

  localparam int SECT  = 2352;
  localparam int BASE  = 12;
  localparam int NCASE = 5;
  localparam int LIMIT = 20000;
  // stimulus table: fill kind (0 random, 1 zeros, 2 ones, 3 ramp), zero flag, seed, mid-run start poke
  localparam int C_KIND [NCASE] = '{0, 0, 3, 1, 2};
  localparam int C_ZERO [NCASE] = '{0, 1, 1, 0, 1};
  localparam int C_SEED [NCASE] = '{1, 77, 5, 0, 0};
  localparam int C_POKE [NCASE] = '{0, 1, 0, 0, 1};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        zero_addr = 1'b0;
  logic        done;
  logic        rd_en, wr_en;
  logic [11:0] rd_addr, wr_addr;
  logic [7:0]  rd_data = 8'h00;
  logic [7:0]  wr_data;

  always #10 clk = ~clk;

  rspc_pgen u_rspc_pgen (
    .clk(clk), .rst(rst), .start(start), .zero_addr(zero_addr), .done(done),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  logic [7:0] mem    [SECT];
  logic [7:0] init_m [SECT];
  logic [7:0] ref_m  [SECT];
  int         hits   [SECT];
  int n_chk = 0, n_bad = 0;
  int wr_cnt = 0, wr_out = 0, rd_out = 0, both_cnt = 0;

  always @(posedge clk) begin
    if (rd_en) begin
      if (rd_addr < 12'(SECT)) rd_data <= mem[rd_addr];
      if (rd_addr < 12'd12 || rd_addr >= 12'd2248) rd_out <= rd_out + 1;
    end
    if (wr_en) begin
      if (wr_addr < 12'(SECT)) begin
        mem[wr_addr]  <= wr_data;
        hits[wr_addr] <= hits[wr_addr] + 1;
      end
      wr_cnt <= wr_cnt + 1;
      if (wr_addr < 12'd2076 || wr_addr >= 12'(SECT)) wr_out <= wr_out + 1;
    end
    if (rd_en && wr_en) both_cnt <= both_cnt + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] t_mulx(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1D : 8'h00);
  endfunction

  function automatic logic [7:0] t_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] s = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= s;
      s = t_mulx(s);
    end
    return r;
  endfunction

  function automatic logic [7:0] t_pow(input int n);
    logic [7:0] r = 8'h01;
    for (int i = 0; i < n; i++) r = t_mulx(r);
    return r;
  endfunction

  function automatic logic [7:0] t_div3(input logic [7:0] x);
    for (int y = 0; y < 256; y++) if (t_mul(8'(y), 8'h03) == x) return 8'(y);
    return 8'h00;
  endfunction

  function automatic int rel_of(input int st, input int step, input int i, input int wrap);
    return (st + i * step) % wrap;
  endfunction

  // Reference parity from the two syndrome sums over the reference image
  task automatic ref_vec(input int st, input int step, input int len, input int wrap,
                         input int zf, output logic [7:0] p0, output logic [7:0] p1);
    logic [7:0] s0 = 8'h00;
    logic [7:0] s1 = 8'h00;
    for (int i = 0; i < len; i++) begin
      int rel = rel_of(st, step, i, wrap);
      logic [7:0] b = (zf != 0 && rel < 4) ? 8'h00 : ref_m[BASE + rel];
      s0 ^= b;
      s1 ^= t_mul(b, t_pow(len + 1 - i));
    end
    p0 = t_div3(s0 ^ s1);
    p1 = p0 ^ s0;
  endtask

  // Both check equations over the design's memory image; returns 1 when satisfied
  function automatic int eq_ok(input int st, input int step, input int len, input int wrap,
                               input int zf, input int a0, input int a1);
    logic [7:0] s0 = 8'h00;
    logic [7:0] s1 = 8'h00;
    for (int i = 0; i < len; i++) begin
      int rel = rel_of(st, step, i, wrap);
      logic [7:0] b = (zf != 0 && rel < 4) ? 8'h00 : mem[BASE + rel];
      s0 ^= b;
      s1 ^= t_mul(b, t_pow(len + 1 - i));
    end
    s0 ^= mem[a0] ^ mem[a1];
    s1 ^= t_mul(mem[a0], 8'h02) ^ mem[a1];
    return (s0 == 8'h00 && s1 == 8'h00) ? 1 : 0;
  endfunction

  task automatic run_case(input int kind, input int zf, input int seed, input int poke);
    logic [31:0] x = 32'(seed);
    int cyc = 0;
    int bad = 0;
    logic [7:0] p0, p1;
    for (int i = 0; i < SECT; i++) begin
      x = x * 32'd1103515245 + 32'd12345;
      case (kind)
        0:       init_m[i] = x[23:16];
        1:       init_m[i] = 8'h00;
        2:       init_m[i] = 8'hFF;
        default: init_m[i] = 8'(i * 7 + seed);
      endcase
      // stale parity contents when the data is flat, so the block must overwrite them
      if ((kind == 1 || kind == 2) && i >= 2076) init_m[i] = 8'hA5;
      mem[i]   = init_m[i];
      ref_m[i] = init_m[i];
      hits[i]  = 0;
    end
    @(negedge clk);
    wr_cnt = 0; wr_out = 0; rd_out = 0; both_cnt = 0;
    start = 1'b1;
    zero_addr = (zf != 0);
    @(negedge clk);
    start = 1'b0;
    zero_addr = (zf == 0);  // R5: must not matter after the start cycle
    while (!done && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      if (poke != 0 && cyc == 500)  start = 1'b1;  // R8
      if (poke != 0 && cyc == 501)  start = 1'b0;
    end
    chk("R7 watchdog / done seen", int'(done), 1);
    chk("R7 writes committed at done", wr_cnt, 276);
    for (int i = 0; i < SECT; i++) if (i >= 2076 && hits[i] != 1) bad++;
    chk("R7 each parity address written once", bad, 0);
    chk("R10 reads outside 12..2247", rd_out, 0);
    chk("R10 writes outside 2076..2351", wr_out, 0);
    chk("R9 read and write in one cycle", both_cnt, 0);
    // reference model: column layer first, then diagonals over the updated image
    for (int k = 0; k < 86; k++) begin
      ref_vec((k >> 1) * 2 + (k & 1), 86, 24, 1 << 30, zf, p0, p1);
      ref_m[BASE + 2064 + k]      = p0;
      ref_m[BASE + 2064 + k + 86] = p1;
    end
    for (int k = 0; k < 52; k++) begin
      ref_vec((k >> 1) * 86 + (k & 1), 88, 43, 2236, zf, p0, p1);
      ref_m[BASE + 2236 + k]      = p0;
      ref_m[BASE + 2236 + k + 52] = p1;
    end
    for (int i = 2076; i < 2248; i++) chk("R2 column parity byte", int'(mem[i]), int'(ref_m[i]));
    for (int i = 2248; i < SECT; i++) chk("R3,R4 diagonal parity byte", int'(mem[i]), int'(ref_m[i]));
    bad = 0;
    for (int i = 0; i < 2076; i++) if (mem[i] != init_m[i]) bad++;
    chk("R5,R10 data and header bytes unchanged", bad, 0);
    bad = 0;
    for (int k = 0; k < 86; k++)
      bad += 1 - eq_ok((k >> 1) * 2 + (k & 1), 86, 24, 1 << 30, zf,
                       BASE + 2064 + k, BASE + 2150 + k);
    chk("R6 column check equations", bad, 0);
    bad = 0;
    for (int k = 0; k < 52; k++)
      bad += 1 - eq_ok((k >> 1) * 86 + (k & 1), 88, 43, 2236, zf,
                       BASE + 2236 + k, BASE + 2288 + k);
    chk("R6 diagonal check equations", bad, 0);
    @(negedge clk);
    chk("R7 done is one cycle", int'(done), 0);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 rd_en in reset", int'(rd_en), 0);
    chk("R1 wr_en in reset", int'(wr_en), 0);
    rst = 1'b0;
    begin
      int act = 0;
      for (int c = 0; c < 12; c++) begin
        @(negedge clk);
        if (rd_en || wr_en || done) act++;
      end
      chk("R1 idle without start", act, 0);
    end
    for (int n = 0; n < NCASE; n++) run_case(C_KIND[n], C_ZERO[n], C_SEED[n], C_POKE[n]);
    // R8: back-to-back job after a poked run still starts cleanly
    run_case(3, 0, 9, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule